// File: doc/BRIEF.md
# Vector Length Control Register

This block is a privileged 64-bit control register that holds a software request for the width of the scalable vector unit. The only writable field is a 4-bit length code LEN in bits [3:0]. It asks for a vector of (LEN+1) x 128 bits. The hardware cannot always provide that width, so the block also drives a separate effective length. This is the widest power-of-two multiple of 128 bits that the build supports and that does not exceed the request. The supported set is always every power of two from 128 bits up to a maximum fixed by a parameter.

Software reaches the register through a system-register access port. The port carries:
- five encoded operand fields,
- a valid strobe and a write flag,
- 64-bit write data,
- the current privilege level (0..3).

Only level 3 may access the register. Lower levels get an undefined-instruction indication. At level 3, an enable bit from a separate trap-control register decides what happens: if it is clear, the access does not complete and a trap to level 3 with syndrome class 0x19 is raised instead. Every response is registered and appears one cycle after the access is presented.

Top module: `veclen_ctrl_reg`

## Requirements
- R1: After synchronous reset, LEN is 0, the effective length is 128, and rd_valid, undef_o and trap_o are low.
- R2: A completed write (level 3, trap_en=1, matching encoding) stores write-data bits [3:0] as LEN. A completed read returns {60'b0, LEN} on rd_data with rd_valid high in the next cycle. Write-data bits [63:4] are never stored and always read as zero.
- R3: eff_len_bits equals 128 x 2^p. Here p is the largest integer with 2^p <= LEN+1, limited to MAX_LOG2 (default 2, which gives a ceiling of 512 bits).
- R4: The effective length reflects a completed write from the cycle after that write is presented.
- R5: A matching access at privilege level 0, 1 or 2 raises undef_o for one cycle. It leaves LEN unchanged and produces no rd_valid.
- R6: A matching access at level 3 with trap_en=0 raises trap_o for one cycle with trap_class = 0x19. It leaves LEN unchanged and produces no rd_valid. trap_class is 0 whenever trap_o is low.
- R7: An access whose encoding does not match raises no flag, returns no data and leaves LEN unchanged.
- R8: The matching encoding is op0=2'b11, op1=3'b110, CRn=4'b0001, CRm=4'b0010, op2=3'b000. It is the same for reads and writes, and a difference in any one field makes the access non-matching.
- R9: When the parameter VEC_PRESENT is 0, every matching access raises undef_o, whatever the privilege level or trap_en.
- R10: At most one of rd_valid, undef_o and trap_o is high in any cycle.
- R11: A read returns the raw LEN as written, not the rounded value. For example, LEN=15 reads back 15 while the effective length is clamped to the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | System-register access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoded operand field op0 |
| acc_op1 | input | 3 | Encoded operand field op1 |
| acc_crn | input | 4 | Encoded operand field CRn |
| acc_crm | input | 4 | Encoded operand field CRm |
| acc_op2 | input | 3 | Encoded operand field op2 |
| acc_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege level |
| trap_en | input | 1 | Access-enable bit from the trap-control register |
| rd_data | output | 64 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Completed read response |
| undef_o | output | 1 | Undefined-instruction indication |
| trap_o | output | 1 | Trap request to level 3 |
| trap_class | output | 6 | Syndrome class, 0x19 while trap_o |
| eff_len_bits | output | 12 | Effective vector length in bits |

## Verification
Two events can land in the same cycle: a completed write changing LEN, and the effective-length output that the very next cycle must already derive from the new LEN. The bench provokes this with back-to-back accesses. A write is followed at once by a read, or by another write with a different code. In the response cycle of each access, the bench compares eff_len_bits and rd_data against a shadow LEN and a rounding function of its own. Random privilege levels, trap enables and encodings are mixed in. They make sure refused accesses that fall between writes leave both the stored code and the effective length untouched.

// File: rtl/veclen_pkg.sv
package veclen_pkg;

    localparam int LEN_W       = 4;
    localparam int BITS_W      = 12;
    localparam int GRAN_SHIFT  = 7;   // 128-bit granule
    localparam int MAX_LOG2_HW = 4;   // architectural ceiling: 2048 bits

    localparam logic [5:0] TRAP_CLASS_VEC = 6'h19;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_UNDEF = 2'd1,
        ACC_TRAP  = 2'd2,
        ACC_OK    = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_enc_t;

    localparam sysreg_enc_t VL_ENC = '{op0: 2'b11, op1: 3'b110,
                                       crn: 4'b0001, crm: 4'b0010,
                                       op2: 3'b000};

    // floor(log2(v)) for v in 1..16
    function automatic logic [2:0] flog2_req(input logic [LEN_W:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 0; i <= MAX_LOG2_HW; i++)
            if (v[i]) r = 3'(i);
        return r;
    endfunction

endpackage

// File: rtl/veclen_decode.sv
module veclen_decode
    import veclen_pkg::*;
#(
    parameter bit VEC_PRESENT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  sysreg_enc_t enc,
    input  logic [1:0]  priv_lvl,
    input  logic        trap_en,
    output acc_kind_e   kind
);

    logic hit;
    assign hit = valid && (enc == VL_ENC);

    always_comb begin
        if (!hit)
            kind = ACC_NONE;
        else if (!VEC_PRESENT || priv_lvl != 2'd3)
            kind = ACC_UNDEF;
        else if (!trap_en)
            kind = ACC_TRAP;
        else
            kind = ACC_OK;
    end

    // R7: a foreign encoding never classifies as anything
    p_foreign_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && enc.crm != VL_ENC.crm) |-> kind == ACC_NONE);
    // R5: lower levels never complete or trap
    p_low_level_undef_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && priv_lvl != 2'd3) |-> kind == ACC_UNDEF);

endmodule

// File: rtl/veclen_round.sv
module veclen_round
    import veclen_pkg::*;
#(
    parameter int MAX_LOG2 = 2
) (
    input  logic [LEN_W-1:0]  len,
    output logic [BITS_W-1:0] eff_bits
);

    localparam logic [2:0] CAP = 3'(MAX_LOG2);

    logic [LEN_W:0] req_mult;
    logic [2:0]     p_raw;
    logic [2:0]     p_cap;

    assign req_mult = {1'b0, len} + 1'b1;
    assign p_raw    = flog2_req(req_mult);
    assign p_cap    = (p_raw > CAP) ? CAP : p_raw;

    generate
        for (genvar g = 0; g <= MAX_LOG2_HW; g++) begin : g_sel
            assign eff_bits[GRAN_SHIFT+g] = (p_cap == 3'(g));
        end
    endgenerate
    assign eff_bits[GRAN_SHIFT-1:0] = '0;

    initial begin
        a_cap_range: assert (MAX_LOG2 >= 0 && MAX_LOG2 <= MAX_LOG2_HW);
    end

endmodule

// File: rtl/veclen_ctrl_reg.sv
module veclen_ctrl_reg
    import veclen_pkg::*;
#(
    parameter bit VEC_PRESENT = 1'b1,
    parameter int MAX_LOG2    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_op0,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [63:0]       acc_wdata,
    input  logic [1:0]        priv_lvl,
    input  logic              trap_en,
    output logic [63:0]       rd_data,
    output logic              rd_valid,
    output logic              undef_o,
    output logic              trap_o,
    output logic [5:0]        trap_class,
    output logic [BITS_W-1:0] eff_len_bits
);

    sysreg_enc_t      enc;
    acc_kind_e        kind;
    logic [LEN_W-1:0] len_q;
    logic             wdata_unused;

    assign enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn,
                   crm: acc_crm, op2: acc_op2};
    assign wdata_unused = ^acc_wdata[63:LEN_W];

    veclen_decode #(.VEC_PRESENT(VEC_PRESENT)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .valid    (acc_valid),
        .enc      (enc),
        .priv_lvl (priv_lvl),
        .trap_en  (trap_en),
        .kind     (kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= '0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            undef_o    <= 1'b0;
            trap_o     <= 1'b0;
            trap_class <= '0;
        end else begin
            rd_valid   <= (kind == ACC_OK) && !acc_write;
            rd_data    <= ((kind == ACC_OK) && !acc_write)
                          ? {{(64-LEN_W){1'b0}}, len_q} : '0;
            undef_o    <= (kind == ACC_UNDEF);
            trap_o     <= (kind == ACC_TRAP);
            trap_class <= (kind == ACC_TRAP) ? TRAP_CLASS_VEC : 6'h00;
            if (kind == ACC_OK && acc_write)
                len_q <= acc_wdata[LEN_W-1:0];
        end
    end

    veclen_round #(.MAX_LOG2(MAX_LOG2)) u_round (
        .len      (len_q),
        .eff_bits (eff_len_bits)
    );

    // R3: effective length is a single power of two not above the request
    p_eff_pow2_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(eff_len_bits) == 1);
    p_eff_le_req_r3: assert property (@(posedge clk) disable iff (rst)
        eff_len_bits <= ((BITS_W'(len_q) + 1'b1) << GRAN_SHIFT));
    // R4: a completed write bounds the next cycle's effective length
    p_write_visible_r4: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_OK && acc_write) |=>
        eff_len_bits <= ((BITS_W'($past(acc_wdata[LEN_W-1:0])) + 1'b1) << GRAN_SHIFT));
    // R5/R6: refused accesses leave the stored code alone
    p_refused_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (undef_o || trap_o) |-> $stable(len_q));
    p_trap_class_r6: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> trap_class == 6'h19);
    // R2: upper read bits are zero
    p_read_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_data[63:LEN_W] == '0);
    // R10: one response kind at a time
    p_one_response_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_valid, undef_o, trap_o}));

endmodule

// File: tb/veclen_ctrl_reg_tb.sv
`timescale 1ns/1ps
module veclen_ctrl_reg_tb_top;

    localparam int MAXL = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_op0 = '0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  priv_lvl = '0;
    logic        trap_en = 1'b0;

    logic [63:0] rd_data, nf_rd_data;
    logic        rd_valid, undef_o, trap_o, nf_rd_valid, nf_undef, nf_trap;
    logic [5:0]  trap_class, nf_class;
    logic [11:0] eff_len_bits, nf_eff;

    int n_cmp = 0, n_bad = 0;
    logic [3:0] shadow_len = 4'd0;

    always #4 clk = ~clk;

    veclen_ctrl_reg #(.VEC_PRESENT(1'b1), .MAX_LOG2(MAXL)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .priv_lvl(priv_lvl), .trap_en(trap_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .undef_o(undef_o), .trap_o(trap_o),
        .trap_class(trap_class), .eff_len_bits(eff_len_bits));

    veclen_ctrl_reg #(.VEC_PRESENT(1'b0), .MAX_LOG2(MAXL)) dut_nf (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .priv_lvl(priv_lvl), .trap_en(trap_en), .rd_data(nf_rd_data),
        .rd_valid(nf_rd_valid), .undef_o(nf_undef), .trap_o(nf_trap),
        .trap_class(nf_class), .eff_len_bits(nf_eff));

    function automatic logic [11:0] exp_eff(input logic [3:0] len);
        int m, p;
        m = int'(len) + 1;
        p = 0;
        for (int i = 0; i <= 4; i++) if (m >= (1 << i)) p = i;
        if (p > MAXL) p = MAXL;
        return 12'(128 << p);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic access(input bit wr, input logic [1:0] o0, input logic [2:0] o1,
                          input logic [3:0] cn, input logic [3:0] cm,
                          input logic [2:0] o2, input logic [63:0] wd,
                          input logic [1:0] lvl, input bit ten);
        bit hit, e_undef, e_trap, e_rd;
        logic [3:0] prev;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_op0 = o0; acc_op1 = o1;
        acc_crn = cn; acc_crm = cm; acc_op2 = o2; acc_wdata = wd;
        priv_lvl = lvl; trap_en = ten;
        hit     = (o0 == 2'b11 && o1 == 3'b110 && cn == 4'b0001 &&
                   cm == 4'b0010 && o2 == 3'b000);
        e_undef = hit && lvl != 2'd3;
        e_trap  = hit && lvl == 2'd3 && !ten;
        e_rd    = hit && lvl == 2'd3 && ten && !wr;
        prev    = shadow_len;
        if (hit && lvl == 2'd3 && ten && wr) shadow_len = wd[3:0];
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(hit ? "R5" : "R7", 64'(undef_o), 64'(e_undef));
        chk(hit ? "R6" : "R7", 64'(trap_o), 64'(e_trap));
        chk("R6", 64'(trap_class), e_trap ? 64'h19 : 64'h0);
        chk(hit ? "R2" : "R7", 64'(rd_valid), 64'(e_rd));
        if (e_rd) chk("R2", rd_data, {60'b0, prev});
        chk("R4", 64'(eff_len_bits), 64'(exp_eff(shadow_len)));
        chk("R10", 64'($countones({rd_valid, undef_o, trap_o}) <= 1), 64'd1);
        chk("R9", 64'(nf_undef), 64'(hit));
        chk("R9", 64'(nf_rd_valid | nf_trap), 64'd0);
    endtask

    task automatic vl_wr(input logic [63:0] wd);
        access(1'b1, 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000, wd, 2'd3, 1'b1);
    endtask
    task automatic vl_rd();
        access(1'b0, 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000, 64'h0, 2'd3, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", 64'(eff_len_bits), 64'd128);
        chk("R1", 64'({rd_valid, undef_o, trap_o}), 64'd0);
        vl_rd();
        chk("R1", rd_data, 64'd0);

        // R2: upper write bits are dropped
        vl_wr(64'hFFFF_FFFF_FFFF_FFF5);
        vl_rd();
        // R11: raw code read back while effective length is clamped
        vl_wr(64'hF);
        vl_rd();
        chk("R11", rd_data, 64'd15);
        chk("R11", 64'(eff_len_bits), 64'd512);
        // R3: every code, write followed directly by read
        for (int k = 0; k < 16; k++) begin
            vl_wr(64'(k));
            vl_rd();
            chk("R3", 64'(eff_len_bits), 64'(exp_eff(4'(k))));
        end
        // R8: one field off at a time is a foreign access
        vl_wr(64'd6);
        access(1'b1, 2'b10, 3'b110, 4'b0001, 4'b0010, 3'b000, 64'd1, 2'd3, 1'b1);
        access(1'b1, 2'b11, 3'b111, 4'b0001, 4'b0010, 3'b000, 64'd1, 2'd3, 1'b1);
        access(1'b1, 2'b11, 3'b110, 4'b0011, 4'b0010, 3'b000, 64'd1, 2'd3, 1'b1);
        access(1'b1, 2'b11, 3'b110, 4'b0001, 4'b0000, 3'b000, 64'd1, 2'd3, 1'b1);
        access(1'b1, 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b001, 64'd1, 2'd3, 1'b1);
        vl_rd();
        chk("R8", rd_data, 64'd6);
        // R5 and R6: refused writes keep the code
        for (int l = 0; l < 3; l++)
            access(1'b1, 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000, 64'd0, 2'(l), 1'b1);
        access(1'b1, 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000, 64'd0, 2'd3, 1'b0);
        access(1'b0, 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000, 64'd0, 2'd3, 1'b0);
        vl_rd();
        chk("R6", rd_data, 64'd6);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] != 3'd0)
                access(r[3], 2'b11, 3'b110, 4'b0001, 4'b0010, 3'b000,
                       {$urandom, $urandom}, r[5:4] | {r[6], r[6]}, r[7] | r[8]);
            else
                access(r[3], 2'(r[10:9]), 3'(r[13:11]), 4'(r[17:14]),
                       4'(r[21:18]), 3'(r[24:22]), {$urandom, $urandom},
                       r[5:4], r[7]);
        end

        summary();
        $finish;
    end

endmodule